// File: doc/BRIEF.md
# Segment Base and Limit Checker

This block forms linear addresses for a 32-bit processor from a segment select and an offset. It keeps six segment registers. Each holds a base, a limit, a writable attribute, a default-size bit (16-bit or 32-bit operands and addresses) and an accessed flag. A load port writes a whole register in one cycle, standing in for the fetch of a descriptor from memory.

For each request the block picks the effective size: the segment default, inverted for this one access when the size-flip input is set. In 16-bit mode only the low 16 bits of the offset take part. The effective offset is checked against the limit and against the write-protect attribute, and is then added to the base. One cycle later the block presents either the linear address with a valid strobe, or a fault with a cause code. With a base of zero and a limit of all ones, a segment is transparent: the linear address equals the offset.

Top module: `seg_addr_check`

## Requirements
- R1: After reset every segment is flat (base 0, limit 0xFFFFFFFF, writable, 32-bit default), all accessed flags are 0, and `addrValid` and `fault` are low.
- R2: A granted request raises `addrValid` on the cycle after it is presented. At that point `linAddr` equals base plus effective offset, modulo 2^32.
- R3: An effective offset greater than the segment limit faults with cause 1 (limit). An offset equal to the limit is allowed.
- R4: A write to a segment whose writable attribute is 0 faults with cause 2 (write-protect), provided the offset is within the limit. Reads of such a segment are granted.
- R5: A select of 6 or 7 faults with cause 3 (bad select), whatever the offset and kind.
- R6: When both the limit check and the write-protect check fail, the cause is 1 (limit).
- R7: The effective size is the segment default-size bit XOR `sizeFlip` (1 = 32-bit) and is reported on `bigOut` with a granted result. In 16-bit mode the offset is truncated to its low 16 bits before both the limit compare and the add.
- R8: The accessed flag of a segment, visible on `segAccessed[i]`, is set by a granted access to that segment and is left unchanged by a faulting one. A load clears it.
- R9: A load replaces base, limit, writable and default size of the selected segment only, and is in effect for requests presented in the following cycle.
- R10: `addrValid` and `fault` are never high together. Both are low in the cycle after a cycle with no request.
- R11: When `addrValid` is low, `linAddr` and `bigOut` are 0. While `fault` is low, `faultCause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Write one segment register this cycle |
| loadSel | input | 3 | Segment to load |
| loadBase | input | 32 | New base |
| loadLimit | input | 32 | New limit (largest legal offset) |
| loadWritable | input | 1 | New writable attribute |
| loadBig | input | 1 | New default size (1 = 32-bit) |
| reqValid | input | 1 | Access request present |
| reqSel | input | 3 | Segment select for the access |
| reqOffset | input | 32 | Access offset |
| reqWrite | input | 1 | 1 = write, 0 = read |
| sizeFlip | input | 1 | Invert default size for this access |
| addrValid | output | 1 | Registered: linear address valid |
| linAddr | output | 32 | Registered linear address |
| bigOut | output | 1 | Registered effective size of a granted access |
| fault | output | 1 | Registered fault strobe |
| faultCause | output | 2 | 0 none, 1 limit, 2 write-protect, 3 bad select |
| segAccessed | output | 6 | Accessed flag per segment |

## Verification
On every cycle the assertions check the output rules that need no model: valid and fault are exclusive, an idle cycle gives idle outputs, a bad select always leads to a bad-select fault, a faulting access leaves the accessed flags alone, and the outputs are zeroed when nothing is valid. The address arithmetic cannot be seen by a property and is left to the bench's sweep. That sweep covers every select, offsets at and around each limit, both access kinds and both size settings, and includes wrap-around of the base add, 16-bit truncation, the cause priority and reloads of a segment.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_LIMIT  = 2'd1,
    CAUSE_WPROT  = 2'd2,
    CAUSE_BADSEL = 2'd3
  } cause_e;

  typedef struct packed {
    logic   grant;
    logic   fault;
    cause_e cause;
    logic   useBig;
  } strobe_t;
endpackage

// File: rtl/seg_check_ctrl.sv
module seg_check_ctrl
  import segchk_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 16,
  localparam int SEL_W  = $clog2(NUM_SEG)
) (
  input  logic              reqValid,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic              reqWrite,
  input  logic              sizeFlip,
  input  logic [ADDR_W-1:0] descLimit,
  input  logic              descWritable,
  input  logic              descBig,
  output logic [ADDR_W-1:0] effOffset,
  output strobe_t           strobes
);
  localparam logic [SEL_W:0] SEG_COUNT = (SEL_W+1)'(NUM_SEG);
  localparam logic [ADDR_W-1:0] LOW_MASK =
    {{(ADDR_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic   selOk;
  logic   useBig;
  cause_e cause;

  always_comb begin
    selOk     = ({1'b0, reqSel} < SEG_COUNT);
    useBig    = descBig ^ sizeFlip;
    effOffset = useBig ? reqOffset : (reqOffset & LOW_MASK);
    // bad select outranks limit, limit outranks write-protect (R5, R6)
    if (!selOk)                         cause = CAUSE_BADSEL;
    else if (effOffset > descLimit)     cause = CAUSE_LIMIT;
    else if (reqWrite && !descWritable) cause = CAUSE_WPROT;
    else                                cause = CAUSE_NONE;
    strobes.grant  = reqValid && (cause == CAUSE_NONE);
    strobes.fault  = reqValid && (cause != CAUSE_NONE);
    strobes.cause  = reqValid ? cause : CAUSE_NONE;
    strobes.useBig = useBig;
  end
endmodule

// File: rtl/seg_check_dp.sv
module seg_check_dp
  import segchk_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int ADDR_W  = 32,
  localparam int SEL_W  = $clog2(NUM_SEG)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic [SEL_W-1:0]   loadSel,
  input  logic [ADDR_W-1:0]  loadBase,
  input  logic [ADDR_W-1:0]  loadLimit,
  input  logic               loadWritable,
  input  logic               loadBig,
  input  logic               reqValid,
  input  logic [SEL_W-1:0]   reqSel,
  input  logic [ADDR_W-1:0]  effOffset,
  input  strobe_t            strobes,
  output logic [ADDR_W-1:0]  descLimit,
  output logic               descWritable,
  output logic               descBig,
  output logic               addrValid,
  output logic [ADDR_W-1:0]  linAddr,
  output logic               bigOut,
  output logic               fault,
  output logic [1:0]         faultCause,
  output logic [NUM_SEG-1:0] segAccessed
);
  logic [ADDR_W-1:0]  baseQ  [NUM_SEG];
  logic [ADDR_W-1:0]  limitQ [NUM_SEG];
  logic [NUM_SEG-1:0] wrQ;
  logic [NUM_SEG-1:0] bigQ;
  logic [NUM_SEG-1:0] accQ;
  logic [SEL_W-1:0]   rdIdx;
  logic [ADDR_W-1:0]  descBase;

  // one register slice per segment
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam logic [SEL_W-1:0] IDX = SEL_W'(s);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[s]  <= '0;
        limitQ[s] <= '1;
        wrQ[s]    <= 1'b1;
        bigQ[s]   <= 1'b1;
        accQ[s]   <= 1'b0;
      end else if (loadEn && loadSel == IDX) begin
        baseQ[s]  <= loadBase;
        limitQ[s] <= loadLimit;
        wrQ[s]    <= loadWritable;
        bigQ[s]   <= loadBig;
        accQ[s]   <= 1'b0;
      end else if (strobes.grant && reqSel == IDX) begin
        accQ[s]   <= 1'b1;
      end
    end
  end

  always_comb begin
    rdIdx        = (int'(reqSel) < NUM_SEG) ? reqSel : '0;
    descBase     = baseQ[rdIdx];
    descLimit    = limitQ[rdIdx];
    descWritable = wrQ[rdIdx];
    descBig      = bigQ[rdIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid  <= 1'b0;
      linAddr    <= '0;
      bigOut     <= 1'b0;
      fault      <= 1'b0;
      faultCause <= 2'd0;
    end else begin
      addrValid  <= strobes.grant;
      linAddr    <= strobes.grant ? (descBase + effOffset) : '0;
      bigOut     <= strobes.grant && strobes.useBig;
      fault      <= strobes.fault;
      faultCause <= strobes.fault ? strobes.cause : CAUSE_NONE;
    end
  end

  assign segAccessed = accQ;

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(addrValid && fault));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!addrValid && !fault));

  a_r5_bad_select: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && int'(reqSel) >= NUM_SEG) |=> (fault && faultCause == 2'd3));

  a_r8_fault_keeps_accessed: assert property (@(posedge clk) disable iff (!rstN)
    (fault && !$past(loadEn)) |-> (segAccessed == $past(segAccessed)));

  a_r11_quiet_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |-> (linAddr == '0 && !bigOut));
endmodule

// File: rtl/seg_addr_check.sv
module seg_addr_check
  import segchk_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 16,
  localparam int SEL_W  = $clog2(NUM_SEG)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic [SEL_W-1:0]   loadSel,
  input  logic [ADDR_W-1:0]  loadBase,
  input  logic [ADDR_W-1:0]  loadLimit,
  input  logic               loadWritable,
  input  logic               loadBig,
  input  logic               reqValid,
  input  logic [SEL_W-1:0]   reqSel,
  input  logic [ADDR_W-1:0]  reqOffset,
  input  logic               reqWrite,
  input  logic               sizeFlip,
  output logic               addrValid,
  output logic [ADDR_W-1:0]  linAddr,
  output logic               bigOut,
  output logic               fault,
  output logic [1:0]         faultCause,
  output logic [NUM_SEG-1:0] segAccessed
);
  strobe_t           strobes;
  logic [ADDR_W-1:0] effOffset;
  logic [ADDR_W-1:0] descLimit;
  logic              descWritable;
  logic              descBig;

  seg_check_ctrl #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_ctrl (
    .reqValid    (reqValid),
    .reqSel      (reqSel),
    .reqOffset   (reqOffset),
    .reqWrite    (reqWrite),
    .sizeFlip    (sizeFlip),
    .descLimit   (descLimit),
    .descWritable(descWritable),
    .descBig     (descBig),
    .effOffset   (effOffset),
    .strobes     (strobes)
  );

  seg_check_dp #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .loadEn      (loadEn),
    .loadSel     (loadSel),
    .loadBase    (loadBase),
    .loadLimit   (loadLimit),
    .loadWritable(loadWritable),
    .loadBig     (loadBig),
    .reqValid    (reqValid),
    .reqSel      (reqSel),
    .effOffset   (effOffset),
    .strobes     (strobes),
    .descLimit   (descLimit),
    .descWritable(descWritable),
    .descBig     (descBig),
    .addrValid   (addrValid),
    .linAddr     (linAddr),
    .bigOut      (bigOut),
    .fault       (fault),
    .faultCause  (faultCause),
    .segAccessed (segAccessed)
  );
endmodule

// File: tb/seg_addr_check_test.sv
module seg_addr_check_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 6;

  logic        clk = 1'b0;
  logic        rstN;
  logic        loadEn, loadWritable, loadBig;
  logic [2:0]  loadSel, reqSel;
  logic [31:0] loadBase, loadLimit, reqOffset;
  logic        reqValid, reqWrite, sizeFlip;
  logic        addrValid, bigOut, fault;
  logic [31:0] linAddr;
  logic [1:0]  faultCause;
  logic [5:0]  segAccessed;

  logic [31:0] mBase [NSEG];
  logic [31:0] mLim  [NSEG];
  logic [5:0]  mWr, mBig, mAcc;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_check uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadSel(loadSel),
    .loadBase(loadBase), .loadLimit(loadLimit), .loadWritable(loadWritable),
    .loadBig(loadBig), .reqValid(reqValid), .reqSel(reqSel),
    .reqOffset(reqOffset), .reqWrite(reqWrite), .sizeFlip(sizeFlip),
    .addrValid(addrValid), .linAddr(linAddr), .bigOut(bigOut),
    .fault(fault), .faultCause(faultCause), .segAccessed(segAccessed)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic loadSeg(input int s, input logic [31:0] b, input logic [31:0] l,
                         input bit w, input bit g);
    @(negedge clk);
    loadEn = 1'b1; loadSel = 3'(s); loadBase = b; loadLimit = l;
    loadWritable = w; loadBig = g;
    @(negedge clk);
    loadEn = 1'b0;
    mBase[s] = b; mLim[s] = l; mWr[s] = w; mBig[s] = g; mAcc[s] = 1'b0;
  endtask

  task automatic runReq(input int s, input logic [31:0] off, input bit wr,
                        input bit flip);
    bit          eV, eF, eB;
    logic [1:0]  eC;
    logic [31:0] eL, eff;
    string       tag;
    @(negedge clk);
    reqValid = 1'b1; reqSel = 3'(s); reqOffset = off; reqWrite = wr; sizeFlip = flip;
    eV = 0; eF = 1; eB = 0; eL = 0;
    if (s >= NSEG) begin
      eC = 2'd3; tag = "R5";
    end else begin
      eB  = mBig[s] ^ flip;
      eff = eB ? off : {16'h0, off[15:0]};
      if (eff > mLim[s]) begin
        eC = 2'd1; tag = (wr && !mWr[s]) ? "R6" : "R3";
      end else if (wr && !mWr[s]) begin
        eC = 2'd2; tag = "R4";
      end else begin
        eC = 2'd0; eF = 0; eV = 1; eL = mBase[s] + eff;
        tag = eB ? "R2" : "R7";
        mAcc[s] = 1'b1;
      end
      if (!eV) eB = 0;
    end
    @(negedge clk);
    check(addrValid == eV, tag, "addrValid", 32'(addrValid), 32'(eV));
    check(fault == eF && !(addrValid && fault), "R10", "fault", 32'(fault), 32'(eF));
    check(faultCause == eC, tag, "faultCause", 32'(faultCause), 32'(eC));
    check(linAddr == eL, eV ? tag : "R11", "linAddr", linAddr, eL);
    check(bigOut == eB, "R7", "bigOut", 32'(bigOut), 32'(eB));
    check(segAccessed == mAcc, "R8", "segAccessed", 32'(segAccessed), 32'(mAcc));
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] offs [9];
    rstN = 1'b0; loadEn = 0; loadSel = 0; loadBase = 0; loadLimit = 0;
    loadWritable = 0; loadBig = 0; reqValid = 0; reqSel = 0; reqOffset = 0;
    reqWrite = 0; sizeFlip = 0;
    for (int s = 0; s < NSEG; s++) begin
      mBase[s] = 32'h0; mLim[s] = 32'hFFFF_FFFF;
    end
    mWr = '1; mBig = '1; mAcc = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!addrValid && !fault, "R1", "outputs idle", {addrValid, fault}, 0);
    check(segAccessed == 6'h0, "R1", "accessed clear", 32'(segAccessed), 0);
    for (int s = 0; s < NSEG; s++) runReq(s, 32'h89AB_CDEF, 1'b1, 1'b0);

    // flat segment 0 stays flat (R11); others configured
    loadSeg(0, 32'h0000_0000, 32'hFFFF_FFFF, 1, 1);
    loadSeg(1, 32'h1000_0000, 32'h0000_0FFF, 1, 1);
    loadSeg(2, 32'hFFFF_F000, 32'h0001_FFFF, 0, 1);
    loadSeg(3, 32'h0002_0000, 32'h0000_8000, 1, 0);
    loadSeg(4, 32'hABCD_0000, 32'h0000_FFFF, 0, 0);
    loadSeg(5, 32'h0000_0010, 32'h0000_0000, 1, 1);
    check(segAccessed == 6'h0, "R8", "cleared by load", 32'(segAccessed), 0);

    for (int s = 0; s < 8; s++) begin
      logic [31:0] lim;
      lim = (s < NSEG) ? mLim[s] : 32'h1000;
      offs[0] = 32'h0; offs[1] = lim; offs[2] = lim + 32'd1; offs[3] = lim - 32'd1;
      offs[4] = 32'h0000_FFFF; offs[5] = 32'h0001_0000; offs[6] = 32'h0001_8001;
      offs[7] = 32'hFFFF_FFFF; offs[8] = 32'h8000_0000;
      for (int k = 0; k < 9; k++)
        for (int w = 0; w < 2; w++)
          for (int f = 0; f < 2; f++)
            runReq(s, offs[k], w[0], f[0]);
    end

    // R9: reload one segment, use it at once, others untouched
    loadSeg(1, 32'h2222_0000, 32'h0000_00FF, 0, 1);
    check(segAccessed[1] == 1'b0, "R9", "reload clears accessed", 32'(segAccessed), 32'(mAcc));
    runReq(1, 32'h0000_00FF, 1'b0, 1'b0);
    runReq(1, 32'h0000_00FF, 1'b1, 1'b0);
    runReq(3, 32'h0000_7FFF, 1'b1, 1'b0);
    runReq(0, 32'h1234_5678, 1'b1, 1'b0);

    // R10: idle cycle after a request gives idle outputs
    @(negedge clk);
    check(!addrValid && !fault, "R10", "idle", {addrValid, fault}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule